// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block collects a parameterised set of level-sensitive peripheral interrupt lines, 32, 64 or 128 of them, and drives one interrupt line to each of up to two processors. Each processor owns a private register bank. A bank holds a group of 32-bit enable words and then a group of read-only status words. A source is steered to a processor by setting its bit in that processor's enable word. The same source may be steered to both processors, or to neither.

Software finds pending sources by reading every status word and masking the result with its own enable words. The block has no priority logic, no vector output, no edge or polarity choice and no set/clear aliases. An enable word changes only when software writes the whole word. Inside each group the words run in reverse order: the word that holds the highest-numbered sources sits at the lowest address. Banks are packed back to back, and the bank stride equals the bank window. Bank 0 serves the boot processor.

Top module: `irqagg_top`

## Requirements
- R1: During reset, and in the cycle after it, every enable bit is 0, every `cpu_irq` bit is 0 and `bus_rdata` is 0.
- R2: Enable word w of bank c sits at byte address c·8·NUM_WORDS + 4·(NUM_WORDS−1−w). A write stores all 32 bits, and a read returns them. With defaults, bank 0 has enable word 1 at 0x00 and enable word 0 at 0x04.
- R3: Status word w of bank c sits at c·8·NUM_WORDS + 4·NUM_WORDS + 4·(NUM_WORDS−1−w). It returns the synchronised raw input levels whatever the enable bits hold. With defaults, bank 0 has status word 1 at 0x08 and status word 0 at 0x0C.
- R4: A write to a status address changes neither any enable bit nor any status readback.
- R5: `cpu_irq[c]` is 1 exactly when some input is high and also enabled in bank c. It follows an input change SYNC_STAGES+1 cycles later (3 by default) and an enable write 1 cycle later.
- R6: Banks are independent. A write to bank c never changes another bank's enables, and one input can drive several processor outputs.
- R7: Outputs are level-following. `cpu_irq[c]` stays 1 while an enabled input stays high, and it drops with the same latency once the input falls.
- R8: An address with nonzero low two bits, or whose bank index is NUM_CPUS or more, is unmapped. A read of it returns 0 and a write to it is ignored.
- R9: `bus_rdata` is registered. It updates on the clock edge that samples a read strobe and holds its value in every other cycle, writes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32·NUM_WORDS | Level interrupt sources, asynchronous |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| cpu_irq | output | NUM_CPUS | Per-processor interrupt request |

## Verification
A corrupted enable bit shows at the ports in two ways. It reads back as the wrong value on the next access to its word. It also raises or masks `cpu_irq` one cycle after the source level reaches the status path. A wrong address decode, such as word order not reversed or banks overlapping, shows up as data in the wrong word or the wrong processor's output on the first cross-check between banks. A bad synchroniser depth shifts the output edge by a cycle, so the bench samples the cycles on both sides of the expected edge.

// File: rtl/irqagg_pkg.sv
// Package: shared constants and the register-group type for the interrupt
// aggregator. Assumes a 32-bit register bus.
package irqagg_pkg;
    localparam int DATA_W = 32;

    // Which register group a bus address falls in
    typedef enum logic [1:0] {
        GRP_ENABLE = 2'd0,
        GRP_STATUS = 2'd1,
        GRP_NONE   = 2'd2
    } grp_e;
endpackage

// File: rtl/irqagg_sync.sv
// Module: multi-stage synchroniser for asynchronous level inputs.
// Assumes inputs are levels held for several cycles; no glitch filtering.
module irqagg_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irqagg_decode.sv
// Module: splits a byte address into register group, bank and word index.
// Assumes the bank stride equals the bank window (8 bytes per word) and that
// inside each group the highest-numbered word sits at the lowest offset.
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    output grp_e               grp,
    output logic [CPU_W-1:0]   cpu_idx,
    output logic [WORD_W-1:0]  word_idx
);
    localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
    localparam int WORD_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int SLOT_W   = $clog2(2 * NUM_WORDS);
    localparam int BANK_LSB = SLOT_W + 2;
    localparam int BANK_W   = ADDR_W - BANK_LSB;

    logic [SLOT_W-1:0] slot;
    logic [BANK_W-1:0] bank;

    assign slot = addr[BANK_LSB-1:2];
    assign bank = addr[ADDR_W-1:BANK_LSB];

    // Classify the address and undo the reversed word order
    always_comb begin
        grp      = GRP_NONE;
        cpu_idx  = '0;
        word_idx = '0;
        if (addr[1:0] == 2'b00 && int'(bank) < NUM_CPUS) begin
            cpu_idx = CPU_W'(bank);
            if (int'(slot) < NUM_WORDS) begin
                grp      = GRP_ENABLE;
                word_idx = WORD_W'(NUM_WORDS - 1 - int'(slot));
            end else begin
                grp      = GRP_STATUS;
                word_idx = WORD_W'(2 * NUM_WORDS - 1 - int'(slot));
            end
        end
    end
endmodule

// File: rtl/irqagg_bank.sv
// Module: one processor's enable storage and its registered request output.
// Assumes whole-word writes only; status comes in already synchronised.
module irqagg_bank
    import irqagg_pkg::*;
#(
    parameter int NUM_WORDS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [WORD_W-1:0]             wr_word,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [NUM_WORDS*DATA_W-1:0]   status,
    output logic [NUM_WORDS*DATA_W-1:0]   en_q,
    output logic                          irq_out
);
    localparam int WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic [NUM_WORDS-1:0][DATA_W-1:0] en_words;

    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_word
            // Replace one enable word on a full-word write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_words[w] <= '0;
                end else if (wr_en && wr_word == WORD_W'(w)) begin
                    en_words[w] <= wr_data;
                end
            end
        end
    endgenerate

    assign en_q = en_words;

    // Register the OR of all enabled, active sources
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
        end else begin
            irq_out <= |(en_q & status);
        end
    end
endmodule

// File: rtl/irqagg_top.sv
// Module: per-processor level interrupt aggregator with a 32-bit register bus.
// Assumes single-cycle bus strobes and NUM_WORDS in {1,2,4}, NUM_CPUS in {1,2}.
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int NUM_WORDS   = 2,
    parameter int NUM_CPUS    = 2,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_WORDS*DATA_W-1:0]  irq_in,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic [NUM_CPUS-1:0]          cpu_irq
);
    localparam int IRQ_W  = NUM_WORDS * DATA_W;
    localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
    localparam int WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    grp_e                              grp;
    logic [CPU_W-1:0]                  cpu_idx;
    logic [WORD_W-1:0]                 word_idx;
    logic [IRQ_W-1:0]                  status;
    logic [NUM_CPUS-1:0][IRQ_W-1:0]    en_all;
    logic [DATA_W-1:0]                 rd_next;

    irqagg_sync #(
        .WIDTH  (IRQ_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_in),
        .dout  (status)
    );

    irqagg_decode #(
        .NUM_WORDS (NUM_WORDS),
        .NUM_CPUS  (NUM_CPUS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr     (bus_addr),
        .grp      (grp),
        .cpu_idx  (cpu_idx),
        .word_idx (word_idx)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CPUS; c++) begin : g_bank
            logic bank_wr;
            assign bank_wr = bus_sel && bus_wr && grp == GRP_ENABLE &&
                             cpu_idx == CPU_W'(c);

            irqagg_bank #(
                .NUM_WORDS (NUM_WORDS)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bank_wr),
                .wr_word (word_idx),
                .wr_data (bus_wdata),
                .status  (status),
                .en_q    (en_all[c]),
                .irq_out (cpu_irq[c])
            );
        end
    endgenerate

    // Select the word a read returns
    always_comb begin
        case (grp)
            GRP_ENABLE: rd_next = en_all[cpu_idx][int'(word_idx)*DATA_W +: DATA_W];
            GRP_STATUS: rd_next = status[int'(word_idx)*DATA_W +: DATA_W];
            default:    rd_next = '0;
        endcase
    end

    // Capture read data on a read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_wr) begin
            bus_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/irqagg_checker.sv
// Module: property checker for irqagg_top, attached by bind.
// Assumes the same parameters as the bound instance.
module irqagg_checker #(
    parameter int NUM_WORDS   = 2,
    parameter int NUM_CPUS    = 2,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_WORDS*32-1:0]          irq_in,
    input logic                             bus_sel,
    input logic                             bus_wr,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [31:0]                      bus_rdata,
    input logic [NUM_CPUS-1:0]              cpu_irq,
    input logic [NUM_CPUS-1:0][NUM_WORDS*32-1:0] en_all
);
    localparam int SLOT_W   = $clog2(2 * NUM_WORDS);
    localparam int BANK_LSB = SLOT_W + 2;
    localparam int BANK_W   = ADDR_W - BANK_LSB;

    logic [BANK_W-1:0] a_bank;
    logic [SLOT_W-1:0] a_slot;
    logic              mapped;
    logic              is_status;
    logic              rd_stb;
    logic              wr_stb;

    assign a_bank    = bus_addr[ADDR_W-1:BANK_LSB];
    assign a_slot    = bus_addr[BANK_LSB-1:2];
    assign mapped    = bus_addr[1:0] == 2'b00 && int'(a_bank) < NUM_CPUS;
    assign is_status = mapped && int'(a_slot) >= NUM_WORDS;
    assign rd_stb    = bus_sel && !bus_wr;
    assign wr_stb    = bus_sel && bus_wr;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cpu_irq == '0 && bus_rdata == '0 && en_all == '0)); // R1

    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && is_status |=> $stable(en_all)); // R4

    AST_OUT_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq != '0 |-> $past(irq_in, SYNC_STAGES + 1) != '0); // R5

    AST_UNMAPPED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && !mapped |=> $stable(en_all)); // R8

    AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !mapped |=> bus_rdata == '0); // R8

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(bus_rdata)); // R9

    genvar c;
    generate
        for (c = 0; c < NUM_CPUS; c++) begin : g_iso
            AST_BANK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
                wr_stb && mapped && !is_status && int'(a_bank) != c
                |=> $stable(en_all[c])); // R6
        end
    endgenerate
endmodule

bind irqagg_top irqagg_checker #(
    .NUM_WORDS   (NUM_WORDS),
    .NUM_CPUS    (NUM_CPUS),
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_irqagg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq),
    .en_all    (en_all)
);

// File: tb/irqagg_top_bench.sv
// Bench: vector table walk, then directed reset, latency and hold tests.
module irqagg_top_bench;
    localparam int OP_IN  = 0;
    localparam int OP_WR  = 1;
    localparam int OP_RD  = 2;
    localparam int OP_OUT = 3;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 28;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 8'h00, 32'h0000_0001, 4'd3}, // R3 source 0 high
        '{2'd2, 8'h0C, 32'h0000_0001, 4'd3}, // R3 status word 0 at 0x0C
        '{2'd2, 8'h08, 32'h0000_0000, 4'd3}, // R3 status word 1 at 0x08
        '{2'd3, 8'h00, 32'h0000_0000, 4'd5}, // R5 not enabled, no request
        '{2'd1, 8'h04, 32'h0000_0001, 4'd2}, // R2 enable word 0 at 0x04
        '{2'd2, 8'h04, 32'h0000_0001, 4'd2}, // R2
        '{2'd2, 8'h00, 32'h0000_0000, 4'd2}, // R2 word 1 untouched
        '{2'd3, 8'h00, 32'h0000_0001, 4'd5}, // R5 cpu0 request
        '{2'd1, 8'h10, 32'h8000_0000, 4'd6}, // R6 bank1 enable word 1
        '{2'd0, 8'h01, 32'h8000_0000, 4'd6}, // R6 source 63 high
        '{2'd3, 8'h00, 32'h0000_0003, 4'd6}, // R6 both outputs
        '{2'd2, 8'h18, 32'h8000_0000, 4'd6}, // R6 bank1 status word 1
        '{2'd2, 8'h00, 32'h0000_0000, 4'd6}, // R6 bank0 word 1 untouched
        '{2'd2, 8'h14, 32'h0000_0000, 4'd6}, // R6 bank1 word 0 untouched
        '{2'd0, 8'h00, 32'h0000_0000, 4'd7}, // R7 source 0 low
        '{2'd3, 8'h00, 32'h0000_0002, 4'd7}, // R7 cpu0 drops
        '{2'd1, 8'h08, 32'hFFFF_FFFF, 4'd4}, // R4 write to status
        '{2'd2, 8'h08, 32'h8000_0000, 4'd4}, // R4 status unchanged
        '{2'd2, 8'h00, 32'h0000_0000, 4'd4}, // R4 enables unchanged
        '{2'd2, 8'h10, 32'h8000_0000, 4'd4}, // R4
        '{2'd1, 8'h20, 32'hFFFF_FFFF, 4'd8}, // R8 bank out of range
        '{2'd2, 8'h20, 32'h0000_0000, 4'd8}, // R8 reads 0
        '{2'd1, 8'h05, 32'hFFFF_FFFF, 4'd8}, // R8 misaligned write
        '{2'd2, 8'h04, 32'h0000_0001, 4'd8}, // R8 enable intact
        '{2'd2, 8'h05, 32'h0000_0000, 4'd8}, // R8 misaligned read 0
        '{2'd3, 8'h00, 32'h0000_0002, 4'd8}, // R8 outputs unchanged
        '{2'd0, 8'h01, 32'h0000_0000, 4'd7}, // R7 source 63 low
        '{2'd3, 8'h00, 32'h0000_0000, 4'd7}  // R7 all quiet
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cpu_irq;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    irqagg_top u_irqagg_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset cpu_irq", 32'(cpu_irq), 32'h0);
        check("R1 reset rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        bus_read(8'h04, rd);
        check("R1 bank0 enable after reset", rd, 32'h0);
        bus_read(8'h10, rd);
        check("R1 bank1 enable after reset", rd, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            case (int'(VECS[i].op))
                OP_IN: begin
                    @(negedge clk);
                    irq_in[int'(VECS[i].addr[0])*32 +: 32] = VECS[i].data;
                    repeat (4) @(negedge clk);
                end
                OP_WR: bus_write(VECS[i].addr, VECS[i].data);
                OP_RD: begin
                    bus_read(VECS[i].addr, rd);
                    check(tag, rd, VECS[i].data);
                end
                default: begin
                    repeat (4) @(negedge clk);
                    check(tag, 32'(cpu_irq), {30'b0, VECS[i].data[1:0]});
                end
            endcase
        end

        // R9: read data holds through idle cycles and writes
        bus_read(8'h04, held);
        repeat (3) @(negedge clk);
        check("R9 hold idle", bus_rdata, held);
        bus_write(8'h14, 32'h0000_0010);
        check("R9 hold on write", bus_rdata, held);

        // R5: three-cycle latency from input to output
        @(negedge clk);
        irq_in[4] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R5 not yet at cycle 2", 32'(cpu_irq), 32'h0);
        @(negedge clk);
        check("R5 request at cycle 3", 32'(cpu_irq), 32'h2);

        // R1: mid-run reset clears enables and outputs
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        irq_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 output after mid reset", 32'(cpu_irq), 32'h0);
        bus_read(8'h14, rd);
        check("R1 bank1 enable cleared", rd, 32'h0);
        bus_read(8'h04, rd);
        check("R1 bank0 enable cleared", rd, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule